// File: doc/BRIEF.md
# Two-Port Hashed Bank Arbiter

This block sits in front of a data store that is split into several single-ported banks. Two requesters may each present one read or one write per cycle. Each address is mapped to a bank by taking the line-interleaved bank bits and XOR-ing them with a group of low tag bits. This spreads addresses that would otherwise pile onto one bank. Requests that land in different banks go ahead in the same cycle. When both land in the same bank, only one goes ahead and the other is held back through its ready signal.

The requester that wins a clash alternates from one clash to the next, so neither port can be locked out. Two reads of the same line in the same cycle share a single bank access, and both ports are answered. Read data comes back on the port that asked for it, one cycle after the grant. The banks are behavioural models that read a whole line and write one word. A per-bank activity vector shows which banks are being driven in the current cycle.

Top module: `mba_top`

## Requirements
- R1: The bank of an address is {a[9]^a[5], a[8]^a[4]}: line bits a[5:4] (16-byte lines) XOR tag bits a[9:8]. For every granted request, its bank's bit in `bank_act` is high in the cycle of the grant. No other bank's bit is high.
- R2: When both ports are valid and their addresses map to different banks, both ready outputs are high in that cycle.
- R3: When both ports are valid for one bank, a port stands alone if it is writing or if the two lines differ. In that case exactly one port is ready, and the bank sees a single access.
- R4: Each time a clash happens, the port that wins is the one that lost the previous clash, so the winner alternates.
- R5: A port that is valid but not ready is not accepted. When it holds its request, it is granted once no clash blocks it, and write data held this way is stored.
- R6: A read granted in cycle t raises `pX_rvalid` on the same port in cycle t+1 and no other cycle. A write never raises `pX_rvalid`.
- R7: Two valid reads of the same line in one cycle are both ready, use exactly one bank access, and each port receives its own word.
- R8: While reset is asserted and after it is released, both `pX_rvalid` outputs are low. After reset, the first clash is won by port 0.
- R9: A read returns the word most recently written to the same word address.
- R10: With a port idle, that port's ready output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_valid | input | 1 | Port 0 request present |
| p0_ready | output | 1 | Port 0 request accepted this cycle |
| p0_write | input | 1 | Port 0: 1 = write, 0 = read |
| p0_addr | input | ADDR_W (12) | Port 0 byte address |
| p0_wdata | input | DATA_W (32) | Port 0 write word |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p0_rdata | output | DATA_W (32) | Port 0 read word |
| p1_valid | input | 1 | Port 1 request present |
| p1_ready | output | 1 | Port 1 request accepted this cycle |
| p1_write | input | 1 | Port 1: 1 = write, 0 = read |
| p1_addr | input | ADDR_W (12) | Port 1 byte address |
| p1_wdata | input | DATA_W (32) | Port 1 write word |
| p1_rvalid | output | 1 | Port 1 read data valid |
| p1_rdata | output | DATA_W (32) | Port 1 read word |
| bank_act | output | NUM_BANKS (4) | One bit per bank, high when that bank is accessed this cycle |

## Verification
Ready and `bank_act` are combinational results of the current request. The bench samples them one time unit after it drives the inputs, within the same cycle. Read responses are registered once, so they are due one cycle after the grant. At each falling edge, the bench first checks the response expected from the previous cycle and only then drives the next request. Every cycle's expected `pX_rvalid` is therefore compared against exactly one grant. The expected read word comes from a reference memory in the bench. That memory is updated only for writes whose port was ready, which means a held write is counted only in the cycle it is finally accepted.

// File: rtl/mba_pkg.sv
package mba_pkg;

  typedef enum logic {PRI_P0 = 1'b0, PRI_P1 = 1'b1} prio_e;

  // Bank selection: line-interleaved bank bits XOR a slice of tag bits.
  function automatic int unsigned bank_of(input int unsigned addr,
                                          input int unsigned off_w,
                                          input int unsigned bank_w,
                                          input int unsigned hash_lsb);
    int unsigned mask;
    mask = (32'd1 << bank_w) - 32'd1;
    return ((addr >> off_w) & mask) ^ ((addr >> hash_lsb) & mask);
  endfunction

  // Row inside a bank: every address bit above the base bank bits.
  function automatic int unsigned row_of(input int unsigned addr,
                                         input int unsigned off_w,
                                         input int unsigned bank_w);
    return addr >> (off_w + bank_w);
  endfunction

  // Word position inside a line.
  function automatic int unsigned word_of(input int unsigned addr,
                                          input int unsigned byte_w,
                                          input int unsigned wsel_w);
    return (addr >> byte_w) & ((32'd1 << wsel_w) - 32'd1);
  endfunction

endpackage

// File: rtl/mba_addr_map.sv
module mba_addr_map #(
  parameter int ADDR_W   = 12,
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 6,
  parameter int WSEL_W   = 2,
  parameter int BYTE_W   = 2,
  parameter int HASH_LSB = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [WSEL_W-1:0] wsel
);
  localparam int OFF_W = WSEL_W + BYTE_W;

  always_comb begin
    bank = BANK_W'(mba_pkg::bank_of(32'(addr), OFF_W, BANK_W, HASH_LSB));
    row  = ROW_W'(mba_pkg::row_of(32'(addr), OFF_W, BANK_W));
    wsel = WSEL_W'(mba_pkg::word_of(32'(addr), BYTE_W, WSEL_W));
  end
endmodule

// File: rtl/mba_arb.sv
module mba_arb #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v0,
  input  logic              w0,
  input  logic [BANK_W-1:0] bank0,
  input  logic [ROW_W-1:0]  row0,
  input  logic              v1,
  input  logic              w1,
  input  logic [BANK_W-1:0] bank1,
  input  logic [ROW_W-1:0]  row1,
  output logic              rdy0,
  output logic              rdy1,
  output logic              clash,
  output logic              merge,
  output mba_pkg::prio_e    prio
);
  import mba_pkg::*;

  logic  same_bank;
  logic  same_line;
  prio_e prio_q;

  always_comb begin
    same_bank = (bank0 == bank1);
    same_line = same_bank && (row0 == row1);
    merge     = v0 && v1 && same_line && !w0 && !w1;
    clash     = v0 && v1 && same_bank && !merge;
    rdy0      = !(clash && (prio_q == PRI_P1));
    rdy1      = !(clash && (prio_q == PRI_P0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= PRI_P0;
    end else if (clash) begin
      prio_q <= (prio_q == PRI_P0) ? PRI_P1 : PRI_P0;
    end
  end

  assign prio = prio_q;
endmodule

// File: rtl/mba_bank_model.sv
module mba_bank_model #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int ROW_W      = 6
) (
  input  logic                         clk,
  input  logic                         en,
  input  logic                         we,
  input  logic [ROW_W-1:0]             row,
  input  logic [$clog2(LINE_WORDS)-1:0] wsel,
  input  logic [DATA_W-1:0]            wdata,
  output logic [LINE_WORDS*DATA_W-1:0] rline
);
  localparam int ROWS = 1 << ROW_W;

  logic [LINE_WORDS-1:0][DATA_W-1:0] mem [ROWS];
  logic [LINE_WORDS-1:0][DATA_W-1:0] rline_q;

  always_ff @(posedge clk) begin
    if (en && we) begin
      mem[row][wsel] <= wdata;
    end
    if (en && !we) begin
      rline_q <= mem[row];
    end
  end

  assign rline = rline_q;
endmodule

// File: rtl/mba_resp_steer.sv
module mba_resp_steer #(
  parameter int DATA_W     = 32,
  parameter int NUM_BANKS  = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   fire_rd,
  input  logic [$clog2(NUM_BANKS)-1:0]           bank,
  input  logic [$clog2(LINE_WORDS)-1:0]          wsel,
  input  logic [NUM_BANKS*LINE_WORDS*DATA_W-1:0] rlines,
  output logic                                   rvalid,
  output logic [DATA_W-1:0]                      rdata
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int WSEL_W = $clog2(LINE_WORDS);

  logic              rvalid_q;
  logic [BANK_W-1:0] bank_q;
  logic [WSEL_W-1:0] wsel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      bank_q   <= '0;
      wsel_q   <= '0;
    end else begin
      rvalid_q <= fire_rd;
      if (fire_rd) begin
        bank_q <= bank;
        wsel_q <= wsel;
      end
    end
  end

  always_comb begin
    int unsigned slot;
    slot  = 32'(bank_q) * LINE_WORDS + 32'(wsel_q);
    rdata = rlines[slot*DATA_W +: DATA_W];
  end

  assign rvalid = rvalid_q;
endmodule

// File: rtl/mba_top.sv
module mba_top #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int NUM_BANKS  = 4,
  parameter int LINE_WORDS = 4,
  parameter int HASH_LSB   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 p0_valid,
  output logic                 p0_ready,
  input  logic                 p0_write,
  input  logic [ADDR_W-1:0]    p0_addr,
  input  logic [DATA_W-1:0]    p0_wdata,
  output logic                 p0_rvalid,
  output logic [DATA_W-1:0]    p0_rdata,
  input  logic                 p1_valid,
  output logic                 p1_ready,
  input  logic                 p1_write,
  input  logic [ADDR_W-1:0]    p1_addr,
  input  logic [DATA_W-1:0]    p1_wdata,
  output logic                 p1_rvalid,
  output logic [DATA_W-1:0]    p1_rdata,
  output logic [NUM_BANKS-1:0] bank_act
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = WSEL_W + BYTE_W;
  localparam int ROW_W  = ADDR_W - OFF_W - BANK_W;
  localparam int LINE_W = LINE_WORDS * DATA_W;

  // Named internal events, also used by the bound checker.
  logic [BANK_W-1:0]   bank0_w, bank1_w;
  logic [ROW_W-1:0]    row0_w, row1_w;
  logic [WSEL_W-1:0]   wsel0_w, wsel1_w;
  logic                grant0_w, grant1_w;
  logic                clash_w, merge_w;
  mba_pkg::prio_e      prio_w;
  logic [NUM_BANKS*LINE_W-1:0] rlines_w;

  mba_addr_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
                 .WSEL_W(WSEL_W), .BYTE_W(BYTE_W), .HASH_LSB(HASH_LSB))
    u_map0 (.addr(p0_addr), .bank(bank0_w), .row(row0_w), .wsel(wsel0_w));

  mba_addr_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
                 .WSEL_W(WSEL_W), .BYTE_W(BYTE_W), .HASH_LSB(HASH_LSB))
    u_map1 (.addr(p1_addr), .bank(bank1_w), .row(row1_w), .wsel(wsel1_w));

  mba_arb #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .v0(p0_valid), .w0(p0_write), .bank0(bank0_w), .row0(row0_w),
    .v1(p1_valid), .w1(p1_write), .bank1(bank1_w), .row1(row1_w),
    .rdy0(p0_ready), .rdy1(p1_ready),
    .clash(clash_w), .merge(merge_w), .prio(prio_w)
  );

  assign grant0_w = p0_valid && p0_ready;
  assign grant1_w = p1_valid && p1_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              hit0, hit1, en, we;
    logic [ROW_W-1:0]  row;
    logic [WSEL_W-1:0] wsel;
    logic [DATA_W-1:0] wdata;

    always_comb begin
      hit0  = grant0_w && (bank0_w == BANK_W'(b));
      hit1  = grant1_w && (bank1_w == BANK_W'(b));
      en    = hit0 || hit1;
      we    = hit0 ? p0_write : (hit1 && p1_write);
      row   = hit0 ? row0_w   : row1_w;
      wsel  = hit0 ? wsel0_w  : wsel1_w;
      wdata = hit0 ? p0_wdata : p1_wdata;
    end

    mba_bank_model #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .ROW_W(ROW_W))
      u_bank (.clk(clk), .en(en), .we(we), .row(row), .wsel(wsel),
              .wdata(wdata), .rline(rlines_w[b*LINE_W +: LINE_W]));

    assign bank_act[b] = en;
  end

  mba_resp_steer #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .LINE_WORDS(LINE_WORDS))
    u_resp0 (.clk(clk), .rst_n(rst_n), .fire_rd(grant0_w && !p0_write),
             .bank(bank0_w), .wsel(wsel0_w), .rlines(rlines_w),
             .rvalid(p0_rvalid), .rdata(p0_rdata));

  mba_resp_steer #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .LINE_WORDS(LINE_WORDS))
    u_resp1 (.clk(clk), .rst_n(rst_n), .fire_rd(grant1_w && !p1_write),
             .bank(bank1_w), .wsel(wsel1_w), .rlines(rlines_w),
             .rvalid(p1_rvalid), .rdata(p1_rdata));

endmodule

// File: rtl/mba_chk.sv
module mba_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 v0,
  input logic                 w0,
  input logic                 rdy0,
  input logic [BANK_W-1:0]    bank0,
  input logic                 v1,
  input logic                 w1,
  input logic                 rdy1,
  input logic [BANK_W-1:0]    bank1,
  input logic                 clash,
  input logic                 merge,
  input logic [NUM_BANKS-1:0] act,
  input logic                 rv0,
  input logic                 rv1
);
  AST_SPLIT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 && v1 && (bank0 != bank1)) |-> (rdy0 && rdy1)); // R2
  AST_CLASH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> ((rdy0 ^ rdy1) && ($countones(act) == 1))); // R3
  AST_ACT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((v0 && rdy0) || (v1 && rdy1)) |-> (act != '0)); // R1
  AST_RR_FROM_P0: assert property (@(posedge clk) disable iff (!rst_n)
    (clash && rdy0) |=> (!clash || rdy1)); // R4
  AST_RR_FROM_P1: assert property (@(posedge clk) disable iff (!rst_n)
    (clash && rdy1) |=> (!clash || rdy0)); // R4
  AST_LOSER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 && !rdy0) |-> (v1 && rdy1)); // R5
  AST_MERGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    merge |-> (rdy0 && rdy1 && ($countones(act) == 1))); // R7
  AST_RESP0_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 && rdy0 && !w0) |=> rv0); // R6
  AST_RESP1_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && rdy1 && !w1) |=> rv1); // R6
  AST_RESP0_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(v0 && rdy0 && !w0) |=> !rv0); // R6
endmodule

bind mba_top mba_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .v0(p0_valid), .w0(p0_write), .rdy0(p0_ready), .bank0(bank0_w),
  .v1(p1_valid), .w1(p1_write), .rdy1(p1_ready), .bank1(bank1_w),
  .clash(clash_w), .merge(merge_w), .act(bank_act),
  .rv0(p0_rvalid), .rv1(p1_rvalid)
);

// File: tb/tb_mba_top.sv
module tb_mba_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p0_valid = 0, p0_write = 0, p1_valid = 0, p1_write = 0;
  logic [11:0] p0_addr = '0, p1_addr = '0;
  logic [31:0] p0_wdata = '0, p1_wdata = '0;
  logic        p0_ready, p1_ready, p0_rvalid, p1_rvalid;
  logic [31:0] p0_rdata, p1_rdata;
  logic [3:0]  bank_act;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mba_top dut (.*);

  // {v0,w0,a0,v1,w1,a1,expected {ready1,ready0}}
  localparam logic [29:0] VEC [12] = '{
    {1'b1,1'b1,12'h000, 1'b1,1'b1,12'h010, 2'b11},
    {1'b1,1'b1,12'h020, 1'b1,1'b1,12'h100, 2'b11},
    {1'b1,1'b1,12'h004, 1'b1,1'b1,12'h040, 2'b01},
    {1'b1,1'b1,12'h110, 1'b1,1'b1,12'h008, 2'b10},
    {1'b1,1'b0,12'h000, 1'b1,1'b0,12'h004, 2'b11},
    {1'b1,1'b0,12'h010, 1'b1,1'b0,12'h100, 2'b01},
    {1'b1,1'b0,12'h020, 1'b1,1'b0,12'h040, 2'b11},
    {1'b1,1'b1,12'h030, 1'b1,1'b0,12'h030, 2'b10},
    {1'b1,1'b0,12'h030, 1'b0,1'b0,12'h000, 2'b11},
    {1'b0,1'b0,12'h000, 1'b1,1'b0,12'h008, 2'b11},
    {1'b1,1'b0,12'h110, 1'b1,1'b0,12'h008, 2'b01},
    {1'b1,1'b0,12'h040, 1'b1,1'b0,12'h000, 2'b10}
  };

  logic [31:0] ref_mem [logic [9:0]];
  logic        pend0 = 0, pend1 = 0, known0 = 0, known1 = 0;
  logic [31:0] want0, want1;

  function automatic logic [1:0] tb_bank(input logic [11:0] a);
    return {a[9] ^ a[5], a[8] ^ a[4]};
  endfunction

  function automatic logic [31:0] tb_wd(input logic [11:0] a);
    return 32'h5A00_0000 | {20'h0, a} | 32'(a) << 16;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_resp();
    chk(p0_rvalid == pend0, "R6", "p0_rvalid", 32'(p0_rvalid), 32'(pend0));
    chk(p1_rvalid == pend1, "R6", "p1_rvalid", 32'(p1_rvalid), 32'(pend1));
    if (pend0 && known0) chk(p0_rdata == want0, "R9", "p0_rdata", p0_rdata, want0);
    if (pend1 && known1) chk(p1_rdata == want1, "R9", "p1_rdata", p1_rdata, want1);
  endtask

  task automatic cyc(input logic v0, input logic w0, input logic [11:0] a0,
                     input logic v1, input logic w1, input logic [11:0] a1,
                     input logic [1:0] exp_rdy, input string req);
    logic g0, g1;
    logic [3:0] exp_act;
    @(negedge clk);
    check_resp();
    p0_valid = v0; p0_write = w0; p0_addr = a0; p0_wdata = tb_wd(a0);
    p1_valid = v1; p1_write = w1; p1_addr = a1; p1_wdata = tb_wd(a1);
    #1;
    chk({p1_ready, p0_ready} == exp_rdy, req, "ready pair",
        32'({p1_ready, p0_ready}), 32'(exp_rdy));
    g0 = v0 && exp_rdy[0];
    g1 = v1 && exp_rdy[1];
    exp_act = '0;
    if (g0) exp_act[tb_bank(a0)] = 1'b1;
    if (g1) exp_act[tb_bank(a1)] = 1'b1;
    chk(bank_act == exp_act, "R1", "bank_act", 32'(bank_act), 32'(exp_act));
    pend0 = g0 && !w0;
    pend1 = g1 && !w1;
    known0 = ref_mem.exists(a0[11:2]);
    known1 = ref_mem.exists(a1[11:2]);
    if (known0) want0 = ref_mem[a0[11:2]];
    if (known1) want1 = ref_mem[a1[11:2]];
    if (g0 && w0) ref_mem[a0[11:2]] = tb_wd(a0);
    if (g1 && w1) ref_mem[a1[11:2]] = tb_wd(a1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    p0_valid = 0; p1_valid = 0;
    pend0 = 0; pend1 = 0;
    repeat (2) @(negedge clk);
    chk(!p0_rvalid && !p1_rvalid, "R8", "rvalid in reset",
        32'({p1_rvalid, p0_rvalid}), 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R10: idle ports are ready, nothing pending
    cyc(0, 0, 12'h0, 0, 0, 12'h0, 2'b11, "R10");

    for (int i = 0; i < 12; i++) begin
      logic [29:0] e;
      string req;
      e = VEC[i];
      if (e[1:0] == 2'b11)
        req = (e[28:27] == 2'b00 && e[14:13] == 2'b00 && e[26:20] == e[12:6]) ? "R7" : "R2";
      else
        req = "R3 R4";
      cyc(e[29], e[28], e[27:16], e[15], e[14], e[13:2], e[1:0], req);
      // R5: the stalled port holds its request alone and is granted
      if (e[29] && !e[0]) cyc(1, e[28], e[27:16], 0, 0, 12'h0, 2'b11, "R5");
      if (e[15] && !e[1]) cyc(0, 0, 12'h0, 1, e[14], e[13:2], 2'b11, "R5");
    end
    cyc(0, 0, 12'h0, 0, 0, 12'h0, 2'b11, "R6");

    // R4: both ports keep clashing on bank 0, winner alternates
    cyc(1, 0, 12'h000, 1, 0, 12'h040, 2'b01, "R4");
    cyc(1, 0, 12'h000, 1, 0, 12'h040, 2'b10, "R4");
    cyc(1, 0, 12'h000, 1, 0, 12'h040, 2'b01, "R4");
    cyc(1, 0, 12'h000, 1, 0, 12'h040, 2'b10, "R4");
    // one clash leaves port 1 favoured; reset must restore port 0
    cyc(1, 0, 12'h000, 1, 0, 12'h040, 2'b01, "R4");
    cyc(0, 0, 12'h0, 0, 0, 12'h0, 2'b11, "R6");
    do_reset();
    cyc(1, 0, 12'h110, 1, 0, 12'h008, 2'b01, "R8");
    // R7: merged reads of different words in one line
    cyc(1, 0, 12'h00C, 1, 0, 12'h008, 2'b11, "R7");
    // R6: write on one port, read on another bank
    cyc(1, 1, 12'h020, 1, 0, 12'h010, 2'b11, "R6");
    cyc(1, 0, 12'h020, 0, 0, 12'h0, 2'b11, "R9");
    cyc(0, 0, 12'h0, 0, 0, 12'h0, 2'b11, "R6");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule